// File: doc/BRIEF.md
# UART Software Flow-Control Controller

This block manages in-band Xon/Xoff flow control for a single UART channel. On the receive path it compares every received character against two host-loadable comparison characters, one for "resume" (Xon) and one for "stop" (Xoff). It records each match in a sticky status field. When automatic transmitter flow control is on, an incoming Xoff halts the transmitter once the character in flight has finished. An incoming Xon restarts it.

On the transmit path the block tells the shifter what to send next: nothing, a FIFO data character, an Xoff, or an Xon. Flow characters requested by the receive side or the host are placed ahead of any queued data. After a flow character the block holds off data for one bit time, and for longer while the FIFO is empty. When automatic receiver flow mode is on, the block also records which flow character it sent last. All of this state appears in one 8-bit status byte. The host reads the byte and pulses `status_rd`, which clears the read-clearable fields.

The transmitter flow machine has four states: FL_NORMAL, FL_HALT_PEND, FL_DISABLED and FL_REENABLED. Its transitions are:
- FL_NORMAL → FL_HALT_PEND on an Xoff match.
- FL_HALT_PEND → FL_DISABLED on character done or an empty FIFO.
- FL_HALT_PEND → FL_REENABLED on an Xon match.
- FL_DISABLED → FL_REENABLED on an Xon match.
- FL_REENABLED → FL_HALT_PEND on an Xoff match.
- FL_REENABLED → FL_NORMAL on a host read.
- Any state → FL_NORMAL when automatic transmitter flow control is turned off.

The character machine has four states: CH_DATA, CH_WAIT, CH_XOFF and CH_XON. Its transitions are:
- Any state → CH_XOFF on an Xoff request.
- Any state → CH_XON on an Xon request.
- CH_XOFF or CH_XON → CH_WAIT when the shifter reports the flow character done.
- CH_WAIT → CH_DATA once the wait counter reaches zero while the FIFO holds data.

Top module: `xflow_ctrl`

## Requirements
- R1: After reset the status byte is 0x00, `tx_sel` is 00 and the comparison characters are Xon = 0x11 and Xoff = 0x13.
- R2: Status bits 7:6 record received matches: bit 6 is set by an Xoff match and bit 7 by an Xon match. So the field reads 01 for Xoff, 10 for Xon and 11 for both. The bits stay set until a host read, and they are updated whether or not any flow mode is enabled.
- R3: A `status_rd` pulse clears bits 7:6 and moves flow code 10 to 00. An event in the same cycle as the read is kept, not lost.
- R4: With `auto_tx_en` high, an Xoff match moves flow bits 3:2 to 01 (halt pending). The next `char_done` or an empty FIFO then moves them to 11 (disabled). In both states `tx_sel` never selects data.
- R5: An Xon match in the halt-pending or disabled state gives flow code 10 (re-enabled), and data selection resumes. Clearing `auto_tx_en` returns the flow code to 00.
- R6: `xoff_req` makes char bits 1:0 read 10 and `tx_sel` read 10. `xon_req` makes them read 11 and 11. A pending flow character is selected ahead of FIFO data. A later request replaces an earlier one, and Xoff wins when both requests arrive in the same cycle.
- R7: A `char_done` while a flow character is selected gives char code 01 (wait) for exactly BIT_CYCLES cycles. The wait lasts longer while `txf_empty` is high. After the wait the code returns to 00 and data may be selected.
- R8: With `auto_rx_en` high, status bits 5:4 read 01 after an Xon is sent and 10 after an Xoff is sent. They never read 11 and are not cleared by a read. They read 00 while `auto_rx_en` is low and are cleared when it goes low.
- R9: Writes through `xon_wr` and `xoff_wr` replace the comparison characters, and later matching uses the new values.
- R10: The `tx_sel` encoding is 00 idle, 01 FIFO data, 10 Xoff, 11 Xon. Data is selected only when the flow code is 00 or 10, the FIFO is not empty and the char code is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wdata | input | CHAR_W | Value for a comparison-character write |
| xon_wr | input | 1 | Load `host_wdata` into the Xon comparison character |
| xoff_wr | input | 1 | Load `host_wdata` into the Xoff comparison character |
| auto_tx_en | input | 1 | Received Xon/Xoff controls the transmitter |
| auto_rx_en | input | 1 | Automatic receiver flow mode (records sent flow characters) |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | CHAR_W | Received character |
| xon_req | input | 1 | Request to insert an Xon |
| xoff_req | input | 1 | Request to insert an Xoff |
| txf_empty | input | 1 | Transmit FIFO empty |
| char_done | input | 1 | Shifter finished the selected character |
| status_rd | input | 1 | Host read of the status byte |
| tx_sel | output | 2 | Next-character select to the shifter |
| status | output | 8 | {received X, auto sent, flow, char} status |

## Verification
The bench builds the block with BIT_CYCLES = 4 and the default 8-bit comparison characters. With those settings it can sweep all 256 received character values through the matcher, each followed by a read, at small cost. The short wait window lets the bench count every cycle of the one-bit-time hold-off exactly and compare it with the case where the FIFO stays empty. The flow and character machines are driven through each named transition, including a read and an event landing in the same cycle.

// File: rtl/xflow_pkg.sv
package xflow_pkg;

    typedef enum logic [1:0] {
        FL_NORMAL    = 2'b00,
        FL_HALT_PEND = 2'b01,
        FL_REENABLED = 2'b10,
        FL_DISABLED  = 2'b11
    } flow_st_e;

    typedef enum logic [1:0] {
        CH_DATA = 2'b00,
        CH_WAIT = 2'b01,
        CH_XOFF = 2'b10,
        CH_XON  = 2'b11
    } char_st_e;

    typedef enum logic [1:0] {
        SEL_IDLE = 2'b00,
        SEL_DATA = 2'b01,
        SEL_XOFF = 2'b10,
        SEL_XON  = 2'b11
    } tx_sel_e;

endpackage

// File: rtl/xflow_rx_match.sv
module xflow_rx_match #(
    parameter int unsigned CHAR_W   = 8,
    parameter logic [CHAR_W-1:0] XON_RST  = 8'h11,
    parameter logic [CHAR_W-1:0] XOFF_RST = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] host_wdata,
    input  logic              xon_wr,
    input  logic              xoff_wr,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              status_rd,
    output logic              xon_hit,
    output logic              xoff_hit,
    output logic [1:0]        seen
);

    logic [CHAR_W-1:0] xon_q, xoff_q;
    logic [1:0]        seen_q, seen_d;

    // comparison characters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xon_q  <= XON_RST;
            xoff_q <= XOFF_RST;
        end else begin
            if (xon_wr)  xon_q  <= host_wdata;
            if (xoff_wr) xoff_q <= host_wdata;
        end
    end

    always_comb begin
        xon_hit  = rx_valid && (rx_data == xon_q);
        xoff_hit = rx_valid && (rx_data == xoff_q);
        seen_d   = (status_rd ? 2'b00 : seen_q) | {xon_hit, xoff_hit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 2'b00;
        else        seen_q <= seen_d;
    end

    assign seen = seen_q;

    AST_SEEN_XOFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_rd && seen_q[0]) |=> seen_q[0]); // R2
    AST_SEEN_XON_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_rd && seen_q[1]) |=> seen_q[1]); // R2
    AST_XOFF_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_hit |=> seen_q[0]); // R3
    AST_XON_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        xon_hit |=> seen_q[1]); // R3

endmodule

// File: rtl/xflow_flow_fsm.sv
module xflow_flow_fsm
    import xflow_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     auto_tx_en,
    input  logic     xon_hit,
    input  logic     xoff_hit,
    input  logic     char_done,
    input  logic     txf_empty,
    input  logic     status_rd,
    output flow_st_e flow_st
);

    flow_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!auto_tx_en) begin
            state_d = FL_NORMAL;
        end else begin
            unique case (state_q)
                FL_NORMAL: begin
                    if (xoff_hit) state_d = FL_HALT_PEND;
                end
                FL_HALT_PEND: begin
                    if (xoff_hit)                    state_d = FL_HALT_PEND;
                    else if (xon_hit)                state_d = FL_REENABLED;
                    else if (char_done || txf_empty) state_d = FL_DISABLED;
                end
                FL_DISABLED: begin
                    if (!xoff_hit && xon_hit) state_d = FL_REENABLED;
                end
                FL_REENABLED: begin
                    if (xoff_hit)       state_d = FL_HALT_PEND;
                    else if (status_rd) state_d = FL_NORMAL;
                end
            endcase
        end
    end

    assign flow_st = state_q;

    AST_DISABLED_VIA_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_DISABLED && $past(state_q) != FL_DISABLED)
            |-> $past(state_q) == FL_HALT_PEND); // R4
    AST_REENABLE_NEEDS_XON: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_REENABLED && $past(state_q) != FL_REENABLED)
            |-> $past(xon_hit)); // R5

endmodule

// File: rtl/xflow_char_fsm.sv
module xflow_char_fsm
    import xflow_pkg::*;
#(
    parameter int unsigned BIT_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xon_req,
    input  logic       xoff_req,
    input  logic       char_done,
    input  logic       txf_empty,
    input  logic       data_ok,
    input  logic       auto_rx_en,
    output char_st_e   char_st,
    output tx_sel_e    tx_sel,
    output logic [1:0] auto_st
);

    localparam int unsigned CNT_W = $clog2(BIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BIT_CYCLES - 1);

    char_st_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [1:0]       auto_q, auto_d;
    logic             sent_flow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_DATA;
            cnt_q   <= '0;
            auto_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            auto_q  <= auto_d;
        end
    end

    always_comb begin
        sent_flow = char_done && (state_q == CH_XOFF || state_q == CH_XON);
        state_d   = state_q;
        cnt_d     = cnt_q;
        if (xoff_req) begin
            state_d = CH_XOFF;
        end else if (xon_req) begin
            state_d = CH_XON;
        end else begin
            unique case (state_q)
                CH_XOFF, CH_XON: begin
                    if (char_done) begin
                        state_d = CH_WAIT;
                        cnt_d   = CNT_LOAD;
                    end
                end
                CH_WAIT: begin
                    if (cnt_q != '0)     cnt_d   = cnt_q - 1'b1;
                    else if (!txf_empty) state_d = CH_DATA;
                end
                CH_DATA: begin
                    state_d = CH_DATA;
                end
            endcase
        end

        if (!auto_rx_en)    auto_d = 2'b00;
        else if (sent_flow) auto_d = (state_q == CH_XON) ? 2'b01 : 2'b10;
        else                auto_d = auto_q;
    end

    // output process
    always_comb begin
        unique case (state_q)
            CH_XOFF: tx_sel = SEL_XOFF;
            CH_XON:  tx_sel = SEL_XON;
            CH_WAIT: tx_sel = SEL_IDLE;
            CH_DATA: tx_sel = (data_ok && !txf_empty) ? SEL_DATA : SEL_IDLE;
        endcase
    end

    assign char_st = state_q;
    assign auto_st = auto_q;

    AST_WAIT_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (sent_flow && !xoff_req && !xon_req) |=> state_q == CH_WAIT); // R7
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_WAIT && cnt_q != '0 && !xoff_req && !xon_req)
            |=> state_q == CH_WAIT); // R7
    AST_AUTO_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        auto_q != 2'b11); // R8
    AST_AUTO_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rx_en |=> auto_q == 2'b00); // R8

endmodule

// File: rtl/xflow_ctrl.sv
module xflow_ctrl
    import xflow_pkg::*;
#(
    parameter int unsigned CHAR_W     = 8,
    parameter logic [CHAR_W-1:0] XON_RST  = 8'h11,
    parameter logic [CHAR_W-1:0] XOFF_RST = 8'h13,
    parameter int unsigned BIT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] host_wdata,
    input  logic              xon_wr,
    input  logic              xoff_wr,
    input  logic              auto_tx_en,
    input  logic              auto_rx_en,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              xon_req,
    input  logic              xoff_req,
    input  logic              txf_empty,
    input  logic              char_done,
    input  logic              status_rd,
    output logic [1:0]        tx_sel,
    output logic [7:0]        status
);

    logic       xon_hit, xoff_hit, data_ok;
    logic [1:0] seen, auto_st;
    flow_st_e   flow_st;
    char_st_e   char_st;
    tx_sel_e    sel;

    xflow_rx_match #(
        .CHAR_W   (CHAR_W),
        .XON_RST  (XON_RST),
        .XOFF_RST (XOFF_RST)
    ) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wdata (host_wdata),
        .xon_wr     (xon_wr),
        .xoff_wr    (xoff_wr),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .status_rd  (status_rd),
        .xon_hit    (xon_hit),
        .xoff_hit   (xoff_hit),
        .seen       (seen)
    );

    xflow_flow_fsm u_flow (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_tx_en (auto_tx_en),
        .xon_hit    (xon_hit),
        .xoff_hit   (xoff_hit),
        .char_done  (char_done),
        .txf_empty  (txf_empty),
        .status_rd  (status_rd),
        .flow_st    (flow_st)
    );

    assign data_ok = (flow_st == FL_NORMAL) || (flow_st == FL_REENABLED);

    xflow_char_fsm #(
        .BIT_CYCLES (BIT_CYCLES)
    ) u_char (
        .clk        (clk),
        .rst_n      (rst_n),
        .xon_req    (xon_req),
        .xoff_req   (xoff_req),
        .char_done  (char_done),
        .txf_empty  (txf_empty),
        .data_ok    (data_ok),
        .auto_rx_en (auto_rx_en),
        .char_st    (char_st),
        .tx_sel     (sel),
        .auto_st    (auto_st)
    );

    assign tx_sel = sel;
    assign status = {seen, auto_st, flow_st, char_st};

    AST_HALT_BLOCKS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_st == FL_HALT_PEND || flow_st == FL_DISABLED) |-> sel != SEL_DATA); // R4
    AST_FLOW_CHAR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (char_st == CH_XOFF || char_st == CH_XON) |-> sel != SEL_DATA); // R6

endmodule

// File: tb/xflow_ctrl_tb.sv
module xflow_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       xon_wr = 0, xoff_wr = 0, auto_tx_en = 0, auto_rx_en = 0;
    logic       rx_valid = 0, xon_req = 0, xoff_req = 0, txf_empty = 1;
    logic       char_done = 0, status_rd = 0;
    logic [7:0] rx_data = '0;
    logic [1:0] tx_sel;
    logic [7:0] status;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    xflow_ctrl #(.BIT_CYCLES(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_wdata(host_wdata), .xon_wr(xon_wr),
        .xoff_wr(xoff_wr), .auto_tx_en(auto_tx_en), .auto_rx_en(auto_rx_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .xon_req(xon_req),
        .xoff_req(xoff_req), .txf_empty(txf_empty), .char_done(char_done),
        .status_rd(status_rd), .tx_sel(tx_sel), .status(status)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rx_char(input logic [7:0] v, input logic rd);
        rx_valid = 1; rx_data = v; status_rd = rd;
        tick();
        rx_valid = 0; status_rd = 0;
    endtask

    task automatic host_read();
        status_rd = 1; tick(); status_rd = 0;
    endtask

    task automatic pulse_done();
        char_done = 1; tick(); char_done = 0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(status, 8'h00, "R1 status after reset");
        chk({6'd0, tx_sel}, 8'h00, "R1 tx_sel after reset");

        // R2 R1: sweep every received value with default compare chars, modes off
        for (int v = 0; v < 256; v++) begin
            rx_char(8'(v), 1'b0);
            chk({6'd0, status[7:6]}, {6'd0, (v == 8'h11), (v == 8'h13)}, "R2 sweep match");
            host_read();
            chk({6'd0, status[7:6]}, 8'h00, "R3 read clears received field");
        end

        rx_char(8'h11, 0);
        rx_char(8'h55, 0);
        rx_char(8'h13, 0);
        chk({6'd0, status[7:6]}, 8'h03, "R2 both received sticky");
        host_read();
        rx_char(8'h13, 1'b1);
        chk({6'd0, status[7:6]}, 8'h01, "R3 event kept over same-cycle read");
        host_read();

        // R9 compare character reload
        host_wdata = 8'h41; xon_wr = 1; tick(); xon_wr = 0;
        rx_char(8'h11, 0);
        chk({6'd0, status[7:6]}, 8'h00, "R9 old Xon value no longer matches");
        rx_char(8'h41, 0);
        chk({6'd0, status[7:6]}, 8'h02, "R9 new Xon value matches");
        host_wdata = 8'h11; xon_wr = 1; status_rd = 1; tick(); xon_wr = 0; status_rd = 0;

        // R4 halt path
        auto_tx_en = 1; txf_empty = 0; tick();
        chk({6'd0, tx_sel}, 8'h01, "R10 data selected when normal");
        rx_char(8'h13, 0);
        chk({6'd0, status[3:2]}, 8'h01, "R4 halt pending");
        chk({6'd0, tx_sel}, 8'h00, "R4 no data while halt pending");
        pulse_done();
        chk({6'd0, status[3:2]}, 8'h03, "R4 disabled after char done");
        chk({6'd0, tx_sel}, 8'h00, "R4 no data while disabled");

        // R5 resume
        rx_char(8'h11, 0);
        chk({6'd0, status[3:2]}, 8'h02, "R5 re-enabled");
        chk({6'd0, tx_sel}, 8'h01, "R5 data resumes");
        host_read();
        chk({6'd0, status[3:2]}, 8'h00, "R3 read returns re-enabled to normal");
        rx_char(8'h13, 0);
        rx_char(8'h11, 0);
        chk({6'd0, status[3:2]}, 8'h02, "R5 re-enabled from halt pending");
        rx_char(8'h13, 1'b1);
        chk({6'd0, status[3:2]}, 8'h01, "R3 Xoff kept over same-cycle read");
        txf_empty = 1; tick();
        chk({6'd0, status[3:2]}, 8'h03, "R4 disabled on empty FIFO");
        txf_empty = 0; auto_tx_en = 0; tick();
        chk({6'd0, status[3:2]}, 8'h00, "R5 mode off returns normal");
        host_read();

        // R6 flow character insertion
        xoff_req = 1; tick(); xoff_req = 0;
        chk({6'd0, status[1:0]}, 8'h02, "R6 Xoff pending code");
        chk({6'd0, tx_sel}, 8'h02, "R6 Xoff selected ahead of data");
        xon_req = 1; tick(); xon_req = 0;
        chk({6'd0, status[1:0]}, 8'h03, "R6 latest request wins");
        chk({6'd0, tx_sel}, 8'h03, "R6 Xon selected");
        xon_req = 1; xoff_req = 1; tick(); xon_req = 0; xoff_req = 0;
        chk({6'd0, tx_sel}, 8'h02, "R6 simultaneous requests give Xoff");

        // R7 R8 wait window and auto status
        auto_rx_en = 1;
        pulse_done();
        chk({6'd0, status[5:4]}, 8'h02, "R8 Xoff sent recorded");
        chk({6'd0, status[1:0]}, 8'h01, "R7 wait cycle 1");
        for (int i = 0; i < 3; i++) begin
            tick();
            chk({6'd0, status[1:0]}, 8'h01, "R7 wait held for bit time");
        end
        tick();
        chk({6'd0, status[1:0]}, 8'h00, "R7 wait ends after BIT_CYCLES");
        chk({6'd0, tx_sel}, 8'h01, "R7 data resumes after wait");

        xon_req = 1; tick(); xon_req = 0;
        txf_empty = 1;
        pulse_done();
        chk({6'd0, status[5:4]}, 8'h01, "R8 Xon sent recorded");
        repeat (10) tick();
        chk({6'd0, status[1:0]}, 8'h01, "R7 wait persists while FIFO empty");
        txf_empty = 0; tick();
        chk({6'd0, status[1:0]}, 8'h00, "R7 wait ends once FIFO has data");
        host_read();
        chk({6'd0, status[5:4]}, 8'h01, "R8 auto field survives read");
        auto_rx_en = 0; tick();
        chk({6'd0, status[5:4]}, 8'h00, "R8 cleared when mode off");
        xoff_req = 1; tick(); xoff_req = 0;
        pulse_done();
        chk({6'd0, status[5:4]}, 8'h00, "R8 stays 00 with mode off");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule